// File: doc/BRIEF.md
# Single-Address Cycle-Steal DMA Channel

This block is one DMA channel that moves data between an addressed external memory region and an external peripheral in the read direction. The peripheral is selected by an acknowledge strobe and not by an address. The channel steals the bus one unit at a time. Each accepted request causes exactly one transfer of a byte or a word. After that transfer the channel drops its bus request, so that the CPU or other masters can run bus cycles before the next request is served.

Before a run, the channel is armed with a start address, a transfer count, a unit size, an address mode and a transfer-end enable. Each completed transfer lowers the count by one. The transfer in which the count reaches zero is the final one. During its access states the channel can raise a transfer-end strobe. After that access it keeps the bus for one idle dead state and then disables itself. A word moved over an 8-bit region becomes two back-to-back byte accesses. Each access takes a parameterised number of states.

Top module: `sadma_chan`

## Requirements
- R1: While reset is active, and on the first cycle after it, `bus_req`, `dack`, `rd` and `tend` are all low.
- R2: If the channel is enabled and `dreq` is high while the channel is idle, `bus_req` goes high on the next cycle. `dack` stays low until `bus_gnt` has been sampled high.
- R3: After the grant, `dack` and `rd` stay high for ACC_STATES cycles per access. A byte transfer uses one access. A word transfer on an 8-bit port (WIDE_PORT=0) uses two accesses, with `addr` equal to the current address and then the current address plus 1.
- R4: After a transfer that is not the final one, `bus_req`, `dack` and `rd` are low on the next cycle.
- R5: With `arm_incr`=1, the address of each transfer is 1 (byte) or 2 (word) above the address of the previous transfer. With `arm_incr`=0 it stays at `arm_addr`.
- R6: With `arm_tend_en`=1, `tend` is high in every access state of the final transfer and low at all other times.
- R7: With `arm_tend_en`=0, `tend` stays low, including during the final transfer.
- R8: Right after the final transfer's access there is exactly one dead cycle: `bus_req` high, and `dack`, `rd` and `tend` low. `bus_req` is low on the cycle after that.
- R9: Once the final transfer has completed, `dreq` is ignored and `bus_req` stays low until the channel is armed again.
- R10: Arming with a count of zero leaves the channel disabled, so `dreq` produces no `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that loads the configuration and enables the channel |
| arm_addr | input | AW | Start address of the memory region |
| arm_count | input | CW | Number of transfers; zero leaves the channel disabled |
| arm_word | input | 1 | 1 = word units, 0 = byte units |
| arm_incr | input | 1 | 1 = address increments after each transfer, 0 = fixed address |
| arm_tend_en | input | 1 | Enables the transfer-end strobe |
| dreq | input | 1 | Transfer request from the peripheral, sampled while the channel is idle |
| bus_req | output | 1 | Bus request; high from request through the dead cycle |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| addr | output | AW | Memory address, valid while `dack` is high |
| rd | output | 1 | Memory read strobe |
| dack | output | 1 | Peripheral acknowledge (selects the device) |
| tend | output | 1 | Transfer-end strobe during the final transfer |

## Verification
The bench sweeps count lengths 1 to 4 over every combination of byte/word, increment/fixed and transfer-end enabled/disabled. For each transfer it computes the expected address, strobe widths and strobe values arithmetically.

Each of the following mistakes produces a distinct, observable failure:
- An off-by-one in the count would flag `tend` one transfer early, or would never reach the dead cycle.
- Splitting a word wrongly would give one access where two are expected, or give the wrong second byte address.
- A missing dead cycle would drop `bus_req` straight after the final access.
- A channel that did not disable itself would answer requests made after the run, or after being armed with a count of zero.

// File: rtl/sadma_pkg.sv
package sadma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_ACC  = 2'd2,
      ST_DEAD = 2'd3
   } seq_st_t;
endpackage

// File: rtl/sadma_ctl.sv
// Holds the transfer count, the enable flag and the run options.
module sadma_ctl #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          word_i,
   input  logic          tend_en_i,
   input  logic          done_i,
   output logic          en_o,
   output logic          last_o,
   output logic          word_o,
   output logic          tend_en_o
);
   logic [CW-1:0] cnt_q;
   logic          en_q;
   logic          word_q;
   logic          ten_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         en_q   <= 1'b0;
         word_q <= 1'b0;
         ten_q  <= 1'b0;
      end else if (arm_i) begin
         cnt_q  <= cnt_i;
         en_q   <= (cnt_i != '0);
         word_q <= word_i;
         ten_q  <= tend_en_i;
      end else if (done_i && en_q) begin
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1))
            en_q <= 1'b0;
      end
   end

   assign en_o      = en_q;
   assign last_o    = (cnt_q == CW'(1));
   assign word_o    = word_q;
   assign tend_en_o = ten_q;
endmodule

// File: rtl/sadma_agen.sv
// Memory-side address: base register, per-transfer step, per-beat offset.
module sadma_agen #(
   parameter int AW        = 16,
   parameter bit WIDE_PORT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic [AW-1:0] base_i,
   input  logic          incr_i,
   input  logic          word_i,
   input  logic          done_i,
   input  logic          beat_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] cur_q;
   logic          inc_q;
   logic [AW-1:0] step;

   assign step = word_i ? AW'(2) : AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         inc_q <= 1'b0;
      end else if (arm_i) begin
         cur_q <= base_i;
         inc_q <= incr_i;
      end else if (done_i && inc_q) begin
         cur_q <= cur_q + step;
      end
   end

   generate
      if (WIDE_PORT) begin : g_wide
         logic unused_beat;
         assign unused_beat = beat_i;
         assign addr_o = cur_q;
      end else begin : g_narrow
         assign addr_o = cur_q + AW'(beat_i);
      end
   endgenerate
endmodule

// File: rtl/sadma_seq.sv
// Bus sequencer: request, grant wait, access beats, dead state.
module sadma_seq
   import sadma_pkg::*;
#(
   parameter int ACC_STATES = 2,
   parameter bit WIDE_PORT  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dreq_i,
   input  logic en_i,
   input  logic last_i,
   input  logic word_i,
   input  logic gnt_i,
   output logic bus_req_o,
   output logic acc_o,
   output logic done_o,
   output logic beat_o
);
   localparam int PHW = (ACC_STATES > 1) ? $clog2(ACC_STATES) : 1;

   seq_st_t        st_q;
   logic [PHW-1:0] ph_q;
   logic           beat_q;
   logic           beat_end;
   logic           nb_last;

   assign beat_end = (ph_q == PHW'(ACC_STATES - 1));

   generate
      if (WIDE_PORT) begin : g_one_beat
         assign nb_last = 1'b1;
      end else begin : g_split_word
         assign nb_last = !word_i || beat_q;
      end
   endgenerate

   assign done_o = (st_q == ST_ACC) && beat_end && nb_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= '0;
         beat_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (dreq_i && en_i) st_q <= ST_REQ;
            ST_REQ: begin
               if (gnt_i) begin
                  st_q   <= ST_ACC;
                  ph_q   <= '0;
                  beat_q <= 1'b0;
               end
            end
            ST_ACC: begin
               if (beat_end) begin
                  ph_q <= '0;
                  if (nb_last) st_q <= last_i ? ST_DEAD : ST_IDLE;
                  else         beat_q <= 1'b1;
               end else begin
                  ph_q <= ph_q + PHW'(1);
               end
            end
            ST_DEAD: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_req_o = (st_q != ST_IDLE);
   assign acc_o     = (st_q == ST_ACC);
   assign beat_o    = beat_q;
endmodule

// File: rtl/sadma_chan.sv
module sadma_chan #(
   parameter int AW         = 16,
   parameter int CW         = 8,
   parameter int ACC_STATES = 2,
   parameter bit WIDE_PORT  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [AW-1:0] arm_addr,
   input  logic [CW-1:0] arm_count,
   input  logic          arm_word,
   input  logic          arm_incr,
   input  logic          arm_tend_en,
   input  logic          dreq,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [AW-1:0] addr,
   output logic          rd,
   output logic          dack,
   output logic          tend
);
   generate
      if (ACC_STATES < 1) begin : g_bad_states
         $error("sadma_chan: ACC_STATES must be at least 1");
      end
      if (AW < 2) begin : g_bad_aw
         $error("sadma_chan: AW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("sadma_chan: CW must be at least 1");
      end
   endgenerate

   logic en, last, word_q, ten_q, done, acc, beat;

   sadma_ctl #(.CW(CW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .cnt_i(arm_count),
      .word_i(arm_word), .tend_en_i(arm_tend_en), .done_i(done),
      .en_o(en), .last_o(last), .word_o(word_q), .tend_en_o(ten_q)
   );

   sadma_agen #(.AW(AW), .WIDE_PORT(WIDE_PORT)) u_agen (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .base_i(arm_addr),
      .incr_i(arm_incr), .word_i(word_q), .done_i(done), .beat_i(beat),
      .addr_o(addr)
   );

   sadma_seq #(.ACC_STATES(ACC_STATES), .WIDE_PORT(WIDE_PORT)) u_seq (
      .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .en_i(en), .last_i(last),
      .word_i(word_q), .gnt_i(bus_gnt), .bus_req_o(bus_req), .acc_o(acc),
      .done_o(done), .beat_o(beat)
   );

   assign dack = acc;
   assign rd   = acc;
   assign tend = acc && last && ten_q;
endmodule

// File: rtl/sadma_chk.sv
module sadma_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_req,
   input logic bus_gnt,
   input logic dack,
   input logic rd,
   input logic tend
);
   // R2: the device is acknowledged only while the bus is requested and granted
   a_r2_ack_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      dack |-> (bus_req && bus_gnt));

   // R3: read strobe and acknowledge move together
   a_r3_rd_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> dack);

   // R6: the end strobe appears only inside an access
   a_r6_tend_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      tend |-> dack);

   // R8: the end strobe falls into the dead cycle
   a_r8_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tend) |-> (bus_req && !dack && !rd));

   // R8: the bus is released right after the dead cycle
   a_r8_release_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tend) |=> !bus_req);
endmodule

bind sadma_chan sadma_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .dack(dack), .rd(rd), .tend(tend)
);

// File: tb/sim_sadma_chan.sv
`timescale 1ns/1ps
module sim_sadma_chan;
   localparam int AW = 16;
   localparam int CW = 8;
   localparam int AS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic [AW-1:0] arm_addr = '0;
   logic [CW-1:0] arm_count = '0;
   logic          arm_word = 1'b0;
   logic          arm_incr = 1'b0;
   logic          arm_tend_en = 1'b0;
   logic          dreq = 1'b0;
   logic          bus_gnt = 1'b0;
   logic          bus_req, rd, dack, tend;
   logic [AW-1:0] addr;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   sadma_chan #(.AW(AW), .CW(CW), .ACC_STATES(AS), .WIDE_PORT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .arm_addr(arm_addr),
      .arm_count(arm_count), .arm_word(arm_word), .arm_incr(arm_incr),
      .arm_tend_en(arm_tend_en), .dreq(dreq), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .addr(addr), .rd(rd), .dack(dack), .tend(tend)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_arm(input int base, input int n, input bit w,
                         input bit inc, input bit ten);
      @(negedge clk);
      arm = 1'b1; arm_addr = AW'(base); arm_count = CW'(n);
      arm_word = w; arm_incr = inc; arm_tend_en = ten;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic do_xfer(input int a0, input bit w, input bit fin,
                          input bit exp_tend, input string areq, input string treq);
      int nb;
      nb = w ? 2 : 1;
      @(negedge clk);
      dreq = 1'b1;
      @(negedge clk);
      check("R2 bus_req", int'(bus_req), 1);
      check("R2 dack before grant", int'(dack), 0);
      dreq = 1'b0;
      bus_gnt = 1'b1;
      for (int i = 0; i < nb * AS; i++) begin
         @(negedge clk);
         check("R3 dack", int'(dack), 1);
         check("R3 rd", int'(rd), 1);
         check(areq, int'(addr), (a0 + i / AS) & 16'hffff);
         check(treq, int'(tend), int'(exp_tend));
      end
      @(negedge clk);
      if (fin) begin
         check("R8 dead bus_req", int'(bus_req), 1);
         check("R8 dead dack", int'(dack), 0);
         check("R8 dead rd", int'(rd), 0);
         check("R8 dead tend", int'(tend), 0);
         @(negedge clk);
         check("R8 release", int'(bus_req), 0);
      end else begin
         check("R4 release bus_req", int'(bus_req), 0);
         check("R4 release dack", int'(dack), 0);
         check("R4 release rd", int'(rd), 0);
      end
      bus_gnt = 1'b0;
   endtask

   task automatic probe_ignored(input string req);
      @(negedge clk);
      dreq = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(req, int'(bus_req), 0);
      end
      dreq = 1'b0;
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: outputs quiet in reset and just after
      repeat (3) @(negedge clk);
      check("R1 bus_req", int'(bus_req), 0);
      check("R1 dack", int'(dack), 0);
      check("R1 tend", int'(tend), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd after reset", int'(rd), 0);
      check("R1 bus_req after reset", int'(bus_req), 0);

      // R10: arming with zero count leaves the channel off
      do_arm(16'h0040, 0, 1'b0, 1'b1, 1'b1);
      probe_ignored("R10 zero count");

      for (int w = 0; w < 2; w++) begin
         for (int inc = 0; inc < 2; inc++) begin
            for (int ten = 0; ten < 2; ten++) begin
               for (int n = 1; n <= 4; n++) begin
                  int base;
                  int a;
                  base = 16'h1000 + 16 * (w * 16 + inc * 8 + ten * 4 + n);
                  if (n == 4) base = 16'hfffe;
                  do_arm(base, n, w[0], inc[0], ten[0]);
                  a = base;
                  for (int k = 0; k < n; k++) begin
                     bit fin;
                     fin = (k == n - 1);
                     do_xfer(a, w[0], fin, ten[0] && fin,
                             (k == 0) ? "R3 addr" : "R5 addr",
                             ten[0] ? "R6 tend" : "R7 tend");
                     if (inc != 0) a = (a + (w != 0 ? 2 : 1)) & 16'hffff;
                  end
                  // R9: no service after the final transfer
                  probe_ignored("R9 disabled after run");
               end
            end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule